// File: doc/BRIEF.md
# Receive FIFO with DMA pipeline

This block buffers bytes handed over by a parallel-port protocol engine and delivers them to a host as 16-bit DMA words. Each incoming byte carries a tag bit and is stored in a 64-entry byte FIFO. Two byte holding stages sit at the FIFO output. Pipeline logic keeps them filled, oldest byte in stage 2 and the next byte in stage 1, and moving one byte per cycle. Together they form the word the host fetches, with the byte order chosen by an input pin.

A DMA request is raised once the FIFO alone (the holding stages not counted) holds at least the programmed threshold. The host is therefore only asked for data after threshold + 2 bytes have arrived. The request stays up across successive word reads. It is withdrawn in the read that leaves fewer than two bytes behind, and whenever a tagged byte reaches a holding stage. A tagged byte cannot travel in a DMA word. Instead it raises an interrupt, and the host removes it by reading that holding stage directly, which clears the stage and its tag.

A flush input empties the FIFO and both stages at once. A full flag tells the port engine to hold off when no space is left.

Top module: `rx_dma_fifo`

## Requirements
- R1: The FIFO stores up to 64 bytes. `fifo_full` is high while 64 bytes are stored, and a write offered while full is dropped without changing any stored byte.
- R2: Bytes move FIFO to stage 1 to stage 2 in arrival order, at most one byte per cycle, and only when the FIFO is non-empty. If stage 2 is empty, stage 1 is full and the FIFO is empty, stage 1 keeps its byte until a new byte arrives.
- R3: With `hi_first`=1, `dma_word[15:8]` is stage 2 (the older byte) and `dma_word[7:0]` is stage 1. With `hi_first`=0 the two halves are swapped.
- R4: `dma_req` rises when the FIFO count is at least `thresh`, both stages are full and neither holds a tag. With `thresh`=4, five bytes give no request and the sixth gives one.
- R5: `dma_ack` while `dma_req` is high empties both stages, which refill on the following cycles. The request stays set if at least two bytes remain in the FIFO after the read and drops in that read otherwise. `dma_ack` while `dma_req` is low has no effect.
- R6: A tagged byte in either stage forces `dma_req` low and drives `irq` = `int_en`. `irq` stays high for as long as a tagged byte remains in a stage.
- R7: `hr_rd1`/`hr_rd2` empty stage 1/stage 2 and clear its tag. `hr_status` bit 0 = stage 1 full, bit 1 = stage 1 tag, bit 2 = stage 2 full, bit 3 = stage 2 tag. `hr1_data`/`hr2_data` show the stage bytes.
- R8: `flush` empties the FIFO and both stages and clears all tags, so `dma_req`, `irq` and `fifo_full` go low on the next cycle.
- R9: After reset, `hr_status`, `dma_req`, `irq` and `fifo_full` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty FIFO and holding stages |
| wr_en | input | 1 | Byte write from the port engine |
| wr_data | input | 8 | Byte written |
| wr_tag | input | 1 | Tag bit of the written byte |
| fifo_full | output | 1 | FIFO holds 64 bytes; writes are dropped |
| thresh | input | 7 | DMA request threshold on FIFO count |
| hi_first | input | 1 | Byte order of the DMA word |
| int_en | input | 1 | Interrupt enable |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA word read strobe |
| dma_word | output | 16 | Packed word from the holding stages |
| hr_rd1 | input | 1 | Direct read of stage 1 |
| hr_rd2 | input | 1 | Direct read of stage 2 |
| hr1_data | output | 8 | Stage 1 byte |
| hr2_data | output | 8 | Stage 2 byte |
| hr_status | output | 4 | Stage full/tag flags |
| irq | output | 1 | Tagged byte in a stage |

## Verification
Every cycle, the assertions check the following. The FIFO count never passes its depth and does not move on a write while full. A stalled stage 1 keeps its byte while the FIFO is empty. A granted word read never takes a tagged byte and always leaves both stages empty. A flush clears all outputs on the next cycle. The interrupt persists while a tag remains unread.

Only the bench scenarios show the following. Byte order and the contents of each word across a full 66-byte drain. The threshold + 2 arrival count. The request surviving reads until fewer than two bytes remain. A dropped write never reappearing. Ignored acknowledges during a tag stall.

// File: rtl/rxq_pkg.sv
// Shared types for the receive FIFO / DMA pipeline.
// Assumes byte-wide port data; a holding stage carries full, tag and data.
package rxq_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              full;
        logic              tag;
        logic [BYTE_W-1:0] data;
    } stage_t;

    localparam stage_t STAGE_EMPTY = '0;
endpackage

// File: rtl/rxq_fifo.sv
// Byte FIFO with tag bit: circular storage, read/write pointers and a fill count.
// Assumes DEPTH is a power of two; pop is only raised when the FIFO is non-empty.
// A push offered while full is dropped.
module rxq_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    // Qualify requests against the fill state.
    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = mem[rd_ptr];
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= din;
    end

    // Pointer and fill-count bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> $stable(count) && $stable(wr_ptr));
endmodule

// File: rtl/rxq_hold.sv
// Two-stage holding pipeline at the FIFO output (stage 1 -> stage 2, oldest in stage 2).
// Assumes take is only raised with both stages full and untagged.
// On a take or direct read cycle the pipeline does not advance; otherwise it pulls at most one byte.
module rxq_hold
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fifo_empty,
    input  logic [BYTE_W:0]   fifo_byte,
    input  logic              take,
    input  logic              rd1,
    input  logic              rd2,
    output logic              pop,
    output stage_t            hr1,
    output stage_t            hr2
);
    logic   busy;
    stage_t incoming;

    // Decide whether a byte is pulled from the FIFO this cycle.
    always_comb begin
        busy     = take || rd1 || rd2;
        pop      = !clr && !fifo_empty && !busy && (!hr1.full || !hr2.full);
        incoming = '{full: 1'b1, tag: fifo_byte[BYTE_W], data: fifo_byte[BYTE_W-1:0]};
    end

    // Stage update: clear, host removal, or forward movement.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hr1 <= STAGE_EMPTY;
            hr2 <= STAGE_EMPTY;
        end else if (busy) begin
            if (take || rd1) hr1 <= STAGE_EMPTY;
            if (take || rd2) hr2 <= STAGE_EMPTY;
        end else if (pop) begin
            if (!hr1.full) begin
                hr1 <= incoming;
            end else begin
                hr2 <= hr1;
                hr1 <= incoming;
            end
        end
    end

    assert_take_untagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (hr1.full && hr2.full && !hr1.tag && !hr2.tag));

    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hr1.full && !hr2.full && fifo_empty && !rd1 && !clr) |=>
        (hr1.full && !hr2.full && $stable(hr1.data)));
endmodule

// File: rtl/rxq_req.sv
// DMA request control: sets on FIFO count >= threshold with a full untagged pipeline.
// Drops on a tag, or on a granted read that leaves fewer than two FIFO bytes.
// Assumes take = granted word read.
module rxq_req #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] thresh,
    input  logic          both_full,
    input  logic          tag_any,
    input  logic          take,
    output logic          dma_req
);
    logic req_q;

    // Request state with set / withdraw conditions.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tag_any) begin
            req_q <= 1'b0;
        end else if (take && count < CW'(2)) begin
            req_q <= 1'b0;
        end else if (!req_q && count >= thresh && both_full) begin
            req_q <= 1'b1;
        end
    end

    // Present the request only while a clean word is ready.
    always_comb dma_req = req_q && both_full && !tag_any;

    assert_short_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && count < CW'(2) && !clr) |=> !req_q);
endmodule

// File: rtl/rx_dma_fifo.sv
// Receive FIFO with DMA pipeline: byte FIFO, two-stage holding pipeline,
// 16-bit word packing with selectable byte order, threshold DMA request and tag interrupt.
// Assumes the host raises dma_ack only while dma_req is high (others are ignored).
module rx_dma_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 64,
    localparam int CW    = $clog2(DEPTH) + 1,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_tag,
    output logic              fifo_full,
    input  logic [CW-1:0]     thresh,
    input  logic              hi_first,
    input  logic              int_en,
    output logic              dma_req,
    input  logic              dma_ack,
    output logic [WORD_W-1:0] dma_word,
    input  logic              hr_rd1,
    input  logic              hr_rd2,
    output logic [BYTE_W-1:0] hr1_data,
    output logic [BYTE_W-1:0] hr2_data,
    output logic [3:0]        hr_status,
    output logic              irq
);
    logic [BYTE_W:0] fifo_byte;
    logic [CW-1:0]   count;
    logic            fifo_empty, pop, take, tag_any, both_full;
    stage_t          hr1, hr2;

    rxq_fifo #(.DEPTH(DEPTH), .W(BYTE_W + 1)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .push(wr_en), .din({wr_tag, wr_data}),
        .pop(pop), .dout(fifo_byte),
        .count(count), .full(fifo_full), .empty(fifo_empty)
    );

    rxq_hold u_hold (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .fifo_empty(fifo_empty), .fifo_byte(fifo_byte),
        .take(take), .rd1(hr_rd1), .rd2(hr_rd2),
        .pop(pop), .hr1(hr1), .hr2(hr2)
    );

    rxq_req #(.CW(CW)) u_req (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .count(count), .thresh(thresh),
        .both_full(both_full), .tag_any(tag_any),
        .take(take), .dma_req(dma_req)
    );

    // Stage summaries, word packing, status and interrupt.
    always_comb begin
        tag_any   = (hr1.full && hr1.tag) || (hr2.full && hr2.tag);
        both_full = hr1.full && hr2.full;
        take      = dma_ack && dma_req;
        dma_word  = hi_first ? {hr2.data, hr1.data} : {hr1.data, hr2.data};
        hr1_data  = hr1.data;
        hr2_data  = hr2.data;
        hr_status = {hr2.tag, hr2.full, hr1.tag, hr1.full};
        irq       = int_en && tag_any;
    end

    assert_take_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && dma_req && !flush) |=> (!hr_status[0] && !hr_status[2]));

    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (hr_status == 4'b0000 && !dma_req && !irq && !fifo_full));

    assert_irq_persist_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !hr_rd1 && !hr_rd2 && !flush) |=> (irq || !int_en));
endmodule

// File: tb/sim_rx_dma_fifo.sv
// Directed bench for rx_dma_fifo: one task per scenario, each checking its own results.
module sim_rx_dma_fifo;
    logic        clk = 1'b0;
    logic        rst_n, flush, wr_en, wr_tag, hi_first, int_en, dma_ack, hr_rd1, hr_rd2;
    logic [7:0]  wr_data;
    logic [6:0]  thresh;
    logic        fifo_full, dma_req, irq;
    logic [15:0] dma_word;
    logic [7:0]  hr1_data, hr2_data;
    logic [3:0]  hr_status;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    rx_dma_fifo u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag), .fifo_full(fifo_full),
        .thresh(thresh), .hi_first(hi_first), .int_en(int_en),
        .dma_req(dma_req), .dma_ack(dma_ack), .dma_word(dma_word),
        .hr_rd1(hr_rd1), .hr_rd2(hr_rd2), .hr1_data(hr1_data), .hr2_data(hr2_data),
        .hr_status(hr_status), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b, input logic t);
        wr_en = 1'b1; wr_data = b; wr_tag = t;
        @(negedge clk);
        wr_en = 1'b0; wr_tag = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic pulse_ack();
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    // R9: reset values
    task automatic t_reset();
        chk("R9 hr_status", {12'h0, hr_status}, 16'h0);
        chk("R9 dma_req", {15'h0, dma_req}, 16'h0);
        chk("R9 irq", {15'h0, irq}, 16'h0);
        chk("R9 fifo_full", {15'h0, fifo_full}, 16'h0);
    endtask

    // R4 / R3: threshold + 2 arrivals, byte order
    task automatic t_threshold();
        do_flush();
        thresh = 7'd4; hi_first = 1'b0;
        for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i), 1'b0);
        idle(4);
        chk("R4 five bytes no req", {15'h0, dma_req}, 16'h0);
        chk("R2 stages full", {12'h0, hr_status}, 16'h0005);
        push(8'hA5, 1'b0);
        idle(3);
        chk("R4 sixth byte req", {15'h0, dma_req}, 16'h1);
        chk("R3 hi_first=0 word", dma_word, 16'hA1A0);
        hi_first = 1'b1;
        #1;
        chk("R3 hi_first=1 word", dma_word, 16'hA0A1);
    endtask

    // R6 / R7 / R5: tagged byte stalls DMA, irq, direct removal, ignored ack
    task automatic t_tag();
        do_flush();
        thresh = 7'd0; hi_first = 1'b1; int_en = 1'b1;
        push(8'hC0, 1'b0); push(8'hC1, 1'b1); push(8'hC2, 1'b0); push(8'hC3, 1'b0);
        idle(4);
        chk("R7 status stage1 tagged", {12'h0, hr_status}, 16'h0007);
        chk("R6 irq on tag", {15'h0, irq}, 16'h1);
        chk("R6 req withheld", {15'h0, dma_req}, 16'h0);
        pulse_ack();
        idle(1);
        chk("R5 ignored ack status", {12'h0, hr_status}, 16'h0007);
        chk("R5 ignored ack data", {8'h0, hr2_data}, 16'h00C0);
        int_en = 1'b0;
        #1;
        chk("R6 irq gated", {15'h0, irq}, 16'h0);
        int_en = 1'b1;
        idle(5);
        chk("R6 irq persists", {15'h0, irq}, 16'h1);
        chk("R7 hr1_data tagged byte", {8'h0, hr1_data}, 16'h00C1);
        hr_rd1 = 1'b1;
        @(negedge clk);
        hr_rd1 = 1'b0;
        idle(2);
        chk("R7 tag cleared refill", {12'h0, hr_status}, 16'h0005);
        chk("R7 irq released", {15'h0, irq}, 16'h0);
        chk("R7 refill byte", {8'h0, hr1_data}, 16'h00C2);
        idle(2);
        chk("R4 req after tag removed", {15'h0, dma_req}, 16'h1);
        chk("R3 word after tag", dma_word, 16'hC0C2);
    endtask

    // R2 / R7 / R8: stage 1 stalls on empty FIFO, then flush
    task automatic t_stall_flush();
        do_flush();
        push(8'hD0, 1'b1); push(8'hD1, 1'b0);
        idle(4);
        chk("R7 status stage2 tagged", {12'h0, hr_status}, 16'h000D);
        hr_rd2 = 1'b1;
        @(negedge clk);
        hr_rd2 = 1'b0;
        idle(4);
        chk("R2 stage1 holds", {12'h0, hr_status}, 16'h0001);
        chk("R2 stage1 byte", {8'h0, hr1_data}, 16'h00D1);
        push(8'hD2, 1'b0);
        idle(3);
        chk("R2 advance status", {12'h0, hr_status}, 16'h0005);
        chk("R2 advance order", {hr2_data, hr1_data}, 16'hD1D2);
        push(8'hD3, 1'b1); push(8'hD4, 1'b0);
        idle(1);
        do_flush();
        chk("R8 status", {12'h0, hr_status}, 16'h0);
        chk("R8 dma_req", {15'h0, dma_req}, 16'h0);
        chk("R8 irq", {15'h0, irq}, 16'h0);
        idle(3);
        chk("R8 fifo emptied", {12'h0, hr_status}, 16'h0);
    endtask

    // R1 / R5: fill to capacity, dropped write, full drain by DMA
    task automatic t_full_drain();
        do_flush();
        thresh = 7'd10; hi_first = 1'b1;
        for (int i = 0; i < 66; i++) push(pat(i), 1'b0);
        idle(4);
        chk("R1 fifo_full", {15'h0, fifo_full}, 16'h1);
        chk("R4 req when full", {15'h0, dma_req}, 16'h1);
        push(8'hEE, 1'b0);
        idle(2);
        for (int k = 0; k < 33; k++) begin
            chk("R5 req before read", {15'h0, dma_req}, 16'h1);
            chk("R1 drained word", dma_word, {pat(2*k), pat(2*k+1)});
            pulse_ack();
            idle(3);
        end
        chk("R5 req dropped at end", {15'h0, dma_req}, 16'h0);
        chk("R1 dropped write absent", {12'h0, hr_status}, 16'h0);
        chk("R1 not full", {15'h0, fifo_full}, 16'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; flush = 1'b0; wr_en = 1'b0; wr_tag = 1'b0; wr_data = '0;
        thresh = '0; hi_first = 1'b1; int_en = 1'b1; dma_ack = 1'b0;
        hr_rd1 = 1'b0; hr_rd2 = 1'b0;
        @(negedge clk);
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_threshold();
        t_tag();
        t_stall_flush();
        t_full_drain();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule